// File: doc/BRIEF.md
# Initiator Bus Phase Sequencer

This block is the control sequencer for one initiator on a shared parallel peripheral bus. A single start request names a target, a transfer direction and, through a command byte stream, the command to send. The sequencer then runs the whole connection. It waits until the bus is idle and arbitrates against the other devices by fixed ID priority. It selects the target, then follows whatever information phase the target puts on the bus. Bytes move through three valid/ready streams: command bytes in, write data in, read data out.

A target can break the connection with a disconnect message. The sequencer then leaves the bus and keeps the pending command context. It continues only when that same target reselects it, and the transfer resumes at the saved data pointer. The sequence ends with a status byte followed by a command-complete message. If the target presents a phase that is not allowed at that point, the sequencer flags an error and drops back to idle.

Bus byte rule: in every information phase the target holds `bus_req` high while it offers or wants a byte. A byte moves in each cycle where `bus_req` and `bus_ack` are both high. On the user streams, `cmd_ready`, `wr_ready` and `rd_valid` are combinational from the bus side. A stream that holds its partner off (`cmd_valid`/`wr_valid` low, or `rd_ready` low) keeps `bus_ack` low, and in that cycle nothing moves and the pointer does not change.

Top module: `bus_phase_seq`

## Requirements
- R1: After reset, `arb_out` is zero and `sel_out`, `done`, `err`, `cmd_ready`, `wr_ready` and `rd_valid` are low. `start` is accepted only while the sequencer is idle and is ignored at any other time, including during a disconnect.
- R2: After accepting `start`, the sequencer does not arbitrate while `bus_busy` is high. It drives arbitration in the cycle after the first cycle in which it sees `bus_busy` low.
- R3: During the single arbitration cycle, `arb_out` holds only bit MY_ID. The sequencer wins only if `arb_in` has no bit set above MY_ID. If it loses, it releases `arb_out`, waits for a free bus again and retries.
- R4: After winning, `sel_out` stays high with `sel_id` equal to the requested target until `sel_ack` is seen, and then the sequencer is connected.
- R5: A byte moves only in a cycle where `bus_req` and `bus_ack` are both high. `bus_ack` is never high without `bus_req`. Phase codes on `tgt_phase`: 0 data-out, 1 data-in, 2 command, 3 status, 7 message-in.
- R6: In the command phase, `cmd_ready` follows `bus_req`, `bus_dout` carries `cmd_byte`, and `bus_ack` follows `cmd_valid`.
- R7: In data phases, write bytes go from `wr_byte` to `bus_dout` and read bytes go from `bus_din` to `rd_byte`, each with valid/ready back-pressure. `xfer_ptr` counts the data bytes moved since `start`.
- R8: A status byte is stored in `status_byte`. A following command-complete message (0x00) pulses `done` for one cycle and returns to idle. A command-complete message with no status byte before it sets `err` instead.
- R9: Message 0x02 saves `xfer_ptr`. Message 0x03 loads the saved value back into `xfer_ptr`. Other message bytes, except 0x00 and 0x04, change nothing.
- R10: Message 0x04 disconnects the sequencer. While disconnected it moves no bytes, and it ignores reselection by any ID other than its target. Reselection by its target reconnects it with `xfer_ptr` set to the saved pointer.
- R11: A phase that is illegal at the current point sets `err`, releases the bus and returns to idle. Illegal cases are: command after a data or status byte, a data phase before any command byte, after status, or in the wrong direction, status before any command byte or a second status, and codes 4 to 6. The next accepted `start` clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run one command |
| start_tgt | input | ID_W | Target ID for the command |
| start_dir | input | 1 | Data direction: 1 reads from target, 0 writes |
| bus_busy | input | 1 | Some device is using the bus |
| arb_in | input | DATA_W | ID bits asserted by other devices during arbitration |
| arb_out | output | DATA_W | Own ID bit, driven while arbitrating |
| sel_out | output | 1 | Selection request to target |
| sel_id | output | ID_W | Target being selected |
| sel_ack | input | 1 | Target answers the selection |
| resel | input | 1 | A target is reselecting this initiator |
| resel_id | input | ID_W | ID of the reselecting target |
| tgt_phase | input | 3 | Information phase driven by the target |
| bus_req | input | 1 | Target offers or wants a byte |
| bus_ack | output | 1 | Initiator takes or supplies the byte |
| bus_din | input | 8 | Byte from target |
| bus_dout | output | 8 | Byte to target |
| cmd_valid | input | 1 | Command byte available |
| cmd_ready | output | 1 | Command byte consumed when valid |
| cmd_byte | input | 8 | Command byte |
| wr_valid | input | 1 | Write data byte available |
| wr_ready | output | 1 | Write byte consumed when valid |
| wr_byte | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data byte available |
| rd_ready | input | 1 | Consumer accepts read byte |
| rd_byte | output | 8 | Read data byte |
| done | output | 1 | One-cycle pulse on command completion |
| status_byte | output | 8 | Last status byte received |
| err | output | 1 | Protocol error flag |
| xfer_ptr | output | PTR_W | Current data byte pointer |

## Verification
The bench first runs a clean write command while the bus is held busy, with a lower-priority rival present, so that waiting, winning and the plain phase order are separated from each other. A second command loses to a higher ID and must retry. A read command is stalled by back-pressure, saves its pointer and disconnects. Stray reselections and a fresh start are offered during the disconnect, then the correct target reselects, which shows whether the context survives and whether the resume point is the saved pointer rather than the live one. Separate runs restore the pointer, send data before any command byte, use the wrong data direction and complete without status, and each of these should produce a distinct outcome.

// File: rtl/bus_phase_seq_pkg.sv
package bus_phase_seq_pkg;
  localparam logic [2:0] PH_DOUT = 3'd0;
  localparam logic [2:0] PH_DIN  = 3'd1;
  localparam logic [2:0] PH_CMD  = 3'd2;
  localparam logic [2:0] PH_STAT = 3'd3;
  localparam logic [2:0] PH_MSGI = 3'd7;

  localparam logic [7:0] MSG_CMPL = 8'h00;
  localparam logic [7:0] MSG_SAVE = 8'h02;
  localparam logic [7:0] MSG_RSTR = 8'h03;
  localparam logic [7:0] MSG_DISC = 8'h04;

  typedef enum logic [2:0] {
    S_IDLE, S_WFREE, S_ARB, S_SEL, S_CONN, S_DISC
  } seq_state_t;

  // progress through the connection so far
  typedef struct packed {
    logic cmd;
    logic dat;
    logic stat;
  } prog_t;
endpackage

// File: rtl/bus_phase_legal.sv
module bus_phase_legal
  import bus_phase_seq_pkg::*;
(
  input  logic [2:0] phase,
  input  logic       dir_rd,
  input  prog_t      seen,
  output logic       legal,
  output logic       is_cmd,
  output logic       is_dout,
  output logic       is_din,
  output logic       is_stat,
  output logic       is_msg
);
  always_comb begin
    is_cmd  = (phase == PH_CMD);
    is_dout = (phase == PH_DOUT);
    is_din  = (phase == PH_DIN);
    is_stat = (phase == PH_STAT);
    is_msg  = (phase == PH_MSGI);
    unique case (phase)
      PH_CMD:  legal = !seen.dat && !seen.stat;
      PH_DOUT: legal = seen.cmd && !seen.stat && !dir_rd;
      PH_DIN:  legal = seen.cmd && !seen.stat && dir_rd;
      PH_STAT: legal = seen.cmd && !seen.stat;
      PH_MSGI: legal = 1'b1;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/bus_id_arb.sv
module bus_id_arb #(
  parameter int DATA_W = 8,
  parameter int MY_ID  = 3
) (
  input  logic [DATA_W-1:0] arb_in,
  output logic [DATA_W-1:0] own_bit,
  output logic              win
);
  localparam logic [DATA_W-1:0] ONE_HOT = {{(DATA_W-1){1'b0}}, 1'b1} << MY_ID;

  assign own_bit = ONE_HOT;

  generate
    if (MY_ID == DATA_W - 1) begin : g_top_prio
      // highest ID never loses; rival bits are irrelevant
      logic unused_rivals;
      assign unused_rivals = ^arb_in;
      assign win = 1'b1;
    end else begin : g_masked
      localparam logic [DATA_W-1:0] HI_MASK = {DATA_W{1'b1}} << (MY_ID + 1);
      assign win = ~|(arb_in & HI_MASK);
    end
  endgenerate
endmodule

// File: rtl/bus_xfer_ptr.sv
module bus_xfer_ptr #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             save,
  input  logic             restore,
  output logic [PTR_W-1:0] cur
);
  logic [PTR_W-1:0] saved;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cur   <= '0;
      saved <= '0;
    end else begin
      if (restore)  cur <= saved;
      else if (inc) cur <= cur + 1'b1;
      if (save)     saved <= cur;
    end
  end

  // R9: a restore lands on the value that was saved
  a_r9_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !clr) |=> (cur == $past(saved)));
endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
  import bus_phase_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MY_ID  = 3,
  parameter int PTR_W  = 16,
  localparam int ID_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ID_W-1:0]   start_tgt,
  input  logic              start_dir,
  input  logic              bus_busy,
  input  logic [DATA_W-1:0] arb_in,
  output logic [DATA_W-1:0] arb_out,
  output logic              sel_out,
  output logic [ID_W-1:0]   sel_id,
  input  logic              sel_ack,
  input  logic              resel,
  input  logic [ID_W-1:0]   resel_id,
  input  logic [2:0]        tgt_phase,
  input  logic              bus_req,
  output logic              bus_ack,
  input  logic [7:0]        bus_din,
  output logic [7:0]        bus_dout,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_byte,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_byte,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_byte,
  output logic              done,
  output logic [7:0]        status_byte,
  output logic              err,
  output logic [PTR_W-1:0]  xfer_ptr
);
  seq_state_t      state;
  logic [ID_W-1:0] tgt;
  logic            dir_rd;
  prog_t           seen;

  logic legal, is_cmd, is_dout, is_din, is_stat, is_msg;
  logic [DATA_W-1:0] own_bit;
  logic won;

  bus_phase_legal u_legal (
    .phase(tgt_phase), .dir_rd(dir_rd), .seen(seen), .legal(legal),
    .is_cmd(is_cmd), .is_dout(is_dout), .is_din(is_din),
    .is_stat(is_stat), .is_msg(is_msg)
  );

  bus_id_arb #(.DATA_W(DATA_W), .MY_ID(MY_ID)) u_arb (
    .arb_in(arb_in), .own_bit(own_bit), .win(won)
  );

  logic active, ok, fire, bad_cmpl, err_evt, resel_hit;
  logic msg_save, msg_rstr;

  always_comb begin
    active    = (state == S_CONN) && bus_req;
    ok        = active && legal;
    cmd_ready = ok && is_cmd;
    wr_ready  = ok && is_dout;
    rd_valid  = ok && is_din;
    rd_byte   = bus_din;
    bus_ack   = ok && ((is_cmd && cmd_valid) || (is_dout && wr_valid) ||
                       (is_din && rd_ready) || is_stat || is_msg);
    bus_dout  = is_cmd ? cmd_byte : (is_dout ? wr_byte : 8'h00);
    fire      = bus_ack;
    bad_cmpl  = fire && is_msg && (bus_din == MSG_CMPL) && !seen.stat;
    err_evt   = (active && !legal) || bad_cmpl;
    resel_hit = (state == S_DISC) && resel && (resel_id == tgt);
    msg_save  = fire && is_msg && (bus_din == MSG_SAVE);
    msg_rstr  = fire && is_msg && (bus_din == MSG_RSTR);
    arb_out   = (state == S_ARB) ? own_bit : '0;
    sel_out   = (state == S_SEL);
    sel_id    = tgt;
  end

  bus_xfer_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .clr((state == S_IDLE) && start),
    .inc(fire && (is_dout || is_din) && !err_evt),
    .save(msg_save),
    .restore(msg_rstr || resel_hit),
    .cur(xfer_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tgt         <= '0;
      dir_rd      <= 1'b0;
      seen        <= '0;
      done        <= 1'b0;
      status_byte <= 8'h00;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          tgt    <= start_tgt;
          dir_rd <= start_dir;
          err    <= 1'b0;
          state  <= S_WFREE;
        end
        S_WFREE: if (!bus_busy) state <= S_ARB;
        S_ARB:   state <= won ? S_SEL : S_WFREE;
        S_SEL: if (sel_ack) begin
          seen  <= '0;
          state <= S_CONN;
        end
        S_CONN: begin
          if (err_evt) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else if (fire) begin
            if (is_cmd) seen.cmd <= 1'b1;
            if (is_dout || is_din) seen.dat <= 1'b1;
            if (is_stat) begin
              seen.stat   <= 1'b1;
              status_byte <= bus_din;
            end
            if (is_msg && bus_din == MSG_CMPL) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
            if (is_msg && bus_din == MSG_DISC) state <= S_DISC;
          end
        end
        S_DISC: if (resel_hit) state <= S_CONN;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: selection is only ever raised right after arbitrating
  a_r4_sel_after_arb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_out) |-> ($past(arb_out) != '0));

  // R5: the initiator never answers a byte the target has not requested
  a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> bus_req);

  // R6: command stream only drains in the command phase
  a_r6_cmd_in_cmd_phase: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (tgt_phase == PH_CMD && bus_req));

  // R7: read stream only offers bytes in the data-in phase
  a_r7_rd_in_din_phase: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (tgt_phase == PH_DIN && bus_req));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: a new error finds the bus released
  a_r11_err_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!sel_out && arb_out == '0 && !bus_ack && !rd_valid));
endmodule

// File: tb/bus_phase_seq_tb.sv
module bus_phase_seq_tb_top;
  import bus_phase_seq_pkg::*;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, start_dir, bus_busy, sel_ack, resel, bus_req;
  logic [2:0] start_tgt, resel_id, tgt_phase, sel_id;
  logic [7:0] arb_in, arb_out, bus_din, bus_dout, cmd_byte, wr_byte, rd_byte, status_byte;
  logic       sel_out, bus_ack, cmd_valid, cmd_ready, wr_valid, wr_ready;
  logic       rd_valid, rd_ready, done, err;
  logic [15:0] xfer_ptr;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_tgt(start_tgt),
    .start_dir(start_dir), .bus_busy(bus_busy), .arb_in(arb_in),
    .arb_out(arb_out), .sel_out(sel_out), .sel_id(sel_id), .sel_ack(sel_ack),
    .resel(resel), .resel_id(resel_id), .tgt_phase(tgt_phase),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_din(bus_din),
    .bus_dout(bus_dout), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_byte(wr_byte), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_byte(rd_byte), .done(done), .status_byte(status_byte), .err(err),
    .xfer_ptr(xfer_ptr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic bus_idle();
    bus_req = 0; cmd_valid = 0; wr_valid = 0; rd_ready = 0; tgt_phase = 3'd4;
  endtask

  // start, win on a free bus, get selected; ends in the connected state
  task automatic connect(input logic [2:0] t, input logic d);
    @(negedge clk); start = 1; start_tgt = t; start_dir = d; bus_busy = 0;
    @(posedge clk); @(negedge clk); start = 0;
    chk("R11 err cleared by start", err, 0);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R4 sel_out", sel_out, 1);
    chk("R4 sel_id", sel_id, t);
    sel_ack = 1;
    @(posedge clk); @(negedge clk);
    sel_ack = 0; bus_busy = 1;
  endtask

  // target-to-initiator byte with consumer ready
  task automatic ib(input logic [2:0] ph, input logic [7:0] b);
    tgt_phase = ph; bus_req = 1; bus_din = b; rd_ready = 1;
    #1 chk("R5 bus_ack on inbound byte", bus_ack, 1);
    @(posedge clk); @(negedge clk);
    bus_idle();
  endtask

  // initiator-to-target byte from command or write stream
  task automatic ob(input logic [2:0] ph, input logic [7:0] b);
    tgt_phase = ph; bus_req = 1;
    if (ph == PH_CMD) begin cmd_valid = 1; cmd_byte = b; end
    else begin wr_valid = 1; wr_byte = b; end
    #1;
    chk("R5 bus_ack on outbound byte", bus_ack, 1);
    if (ph == PH_CMD) chk("R6 cmd_ready", cmd_ready, 1);
    else chk("R7 wr_ready", wr_ready, 1);
    chk("R6 R7 bus_dout", bus_dout, b);
    @(posedge clk); @(negedge clk);
    bus_idle();
  endtask

  task automatic finish_ok(input logic [7:0] st);
    ib(PH_STAT, st);
    ib(PH_MSGI, MSG_CMPL);
    chk("R8 done pulse", done, 1);
    chk("R8 status_byte", status_byte, st);
    chk("R8 no err", err, 0);
    @(negedge clk);
    chk("R8 done single cycle", done, 0);
    bus_busy = 0;
  endtask

  task automatic t_reset();
    chk("R1 arb_out reset", arb_out, 0);
    chk("R1 sel_out reset", sel_out, 0);
    chk("R1 done reset", done, 0);
    chk("R1 err reset", err, 0);
    chk("R1 rd_valid reset", rd_valid, 0);
    chk("R1 cmd_ready reset", cmd_ready, 0);
  endtask

  task automatic t_write();
    @(negedge clk); start = 1; start_tgt = 3'd2; start_dir = 0; bus_busy = 1;
    @(posedge clk); @(negedge clk); start = 0;
    chk("R2 no arb while busy", arb_out, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 still waiting", arb_out, 0);
    bus_busy = 0;
    @(posedge clk); @(negedge clk);
    chk("R3 own ID bit", arb_out, 8'h08);
    arb_in = 8'h02;
    @(posedge clk); @(negedge clk);
    arb_in = 0;
    chk("R3 win over lower ID", sel_out, 1);
    chk("R4 sel_id", sel_id, 2);
    @(posedge clk); @(negedge clk);
    chk("R4 selection held", sel_out, 1);
    sel_ack = 1;
    @(posedge clk); @(negedge clk);
    sel_ack = 0; bus_busy = 1;
    chk("R4 selection dropped", sel_out, 0);
    ob(PH_CMD, 8'h2A); ob(PH_CMD, 8'h11);
    tgt_phase = PH_CMD; bus_req = 1; cmd_valid = 0;
    #1 chk("R6 no ack without cmd_valid", bus_ack, 0);
    @(posedge clk); @(negedge clk); bus_idle();
    ob(PH_DOUT, 8'hA1); ob(PH_DOUT, 8'hA2); ob(PH_DOUT, 8'hA3);
    chk("R7 xfer_ptr after writes", xfer_ptr, 3);
    finish_ok(8'h08);
  endtask

  task automatic t_lose();
    @(negedge clk); start = 1; start_tgt = 3'd1; start_dir = 0; bus_busy = 0;
    @(posedge clk); @(negedge clk); start = 0;
    @(posedge clk); @(negedge clk);
    arb_in = 8'h20;
    @(posedge clk); @(negedge clk);
    arb_in = 0;
    chk("R3 lost: no selection", sel_out, 0);
    chk("R3 lost: arb released", arb_out, 0);
    @(posedge clk); @(negedge clk);
    chk("R3 retry arbitration", arb_out, 8'h08);
    @(posedge clk); @(negedge clk);
    chk("R3 retry wins", sel_out, 1);
    sel_ack = 1;
    @(posedge clk); @(negedge clk);
    sel_ack = 0; bus_busy = 1;
    ob(PH_CMD, 8'h00);
    finish_ok(8'h00);
  endtask

  task automatic t_read_disc();
    connect(3'd5, 1);
    ob(PH_CMD, 8'h28);
    tgt_phase = PH_DIN; bus_req = 1; bus_din = 8'h55; rd_ready = 0;
    #1;
    chk("R7 rd_valid offered", rd_valid, 1);
    chk("R7 rd_byte", rd_byte, 8'h55);
    chk("R7 back-pressure holds ack", bus_ack, 0);
    @(posedge clk); @(negedge clk); bus_idle();
    chk("R7 ptr unchanged while stalled", xfer_ptr, 0);
    ib(PH_DIN, 8'h55); ib(PH_DIN, 8'h56);
    ib(PH_MSGI, MSG_SAVE);
    ib(PH_DIN, 8'h57);
    chk("R7 ptr after reads", xfer_ptr, 3);
    ib(PH_MSGI, MSG_DISC);
    bus_busy = 0;
    tgt_phase = PH_DIN; bus_req = 1; rd_ready = 1;
    #1 chk("R10 no transfer while disconnected", rd_valid, 0);
    bus_idle();
    start = 1; start_tgt = 3'd6;
    @(posedge clk); @(negedge clk); start = 0;
    resel = 1; resel_id = 3'd6;
    @(posedge clk); @(negedge clk);
    resel_id = 3'd4;
    @(posedge clk); @(negedge clk); resel = 0;
    tgt_phase = PH_DIN; bus_req = 1; rd_ready = 1;
    #1 chk("R10 R1 foreign reselect and start ignored", rd_valid, 0);
    bus_idle();
    chk("R10 pointer kept while away", xfer_ptr, 3);
    resel = 1; resel_id = 3'd5;
    @(posedge clk); @(negedge clk); resel = 0; bus_busy = 1;
    chk("R10 resume at saved pointer", xfer_ptr, 2);
    ib(PH_MSGI, 8'h80);
    chk("R9 other message ignored", xfer_ptr, 2);
    ib(PH_DIN, 8'h57);
    chk("R10 transfer continues", xfer_ptr, 3);
    finish_ok(8'h02);
  endtask

  task automatic t_restore();
    connect(3'd1, 1);
    ob(PH_CMD, 8'h08);
    ib(PH_DIN, 8'h01);
    ib(PH_MSGI, MSG_SAVE);
    ib(PH_DIN, 8'h02); ib(PH_DIN, 8'h03);
    chk("R9 ptr before restore", xfer_ptr, 3);
    ib(PH_MSGI, MSG_RSTR);
    chk("R9 restore pointer", xfer_ptr, 1);
    finish_ok(8'h00);
  endtask

  task automatic t_bad_phase();
    connect(3'd2, 0);
    tgt_phase = PH_DOUT; bus_req = 1; wr_valid = 1;
    #1 chk("R11 no ack on illegal phase", bus_ack, 0);
    @(posedge clk); @(negedge clk); bus_idle();
    chk("R11 err on data before command", err, 1);
    chk("R11 bus released", sel_out, 0);
    bus_busy = 0;
    connect(3'd2, 0);
    ob(PH_CMD, 8'h0A);
    tgt_phase = PH_DIN; bus_req = 1; rd_ready = 1;
    #1 chk("R11 R7 wrong direction not offered", rd_valid, 0);
    @(posedge clk); @(negedge clk); bus_idle();
    chk("R11 err on wrong direction", err, 1);
    bus_busy = 0;
    connect(3'd3, 1);
    ob(PH_CMD, 8'h00);
    ib(PH_MSGI, MSG_CMPL);
    chk("R8 complete without status: err", err, 1);
    chk("R8 complete without status: no done", done, 0);
    bus_busy = 0;
  endtask

  initial begin
    rst_n = 0; start = 0; start_tgt = 0; start_dir = 0; bus_busy = 0;
    arb_in = 0; sel_ack = 0; resel = 0; resel_id = 0; bus_din = 0;
    cmd_byte = 0; wr_byte = 0; bus_idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_write();
    t_lose();
    t_read_disc();
    t_restore();
    t_bad_phase();
    summary();
    $finish;
  end
endmodule